// File: doc/BRIEF.md
# Multiplexed Status Display Scanner

This block drives a row of four common-anode seven-segment digits whose cathode lines are shared, lighting one digit at a time fast enough that all four appear steady. The leftmost digit shows the number of the controller state taken from a 16-bit one-hot state bus. The rightmost digit shows a direction glyph: an 'L' for left, or an 'A' shape that stands in for 'R', since 'R' cannot be drawn on seven segments. The two middle digits stay dark.

A free-running refresh counter advances on every clock. Its two top bits pick the digit, drive the anode decoder and steer the cathode multiplexer, so the anode order and the cathode data always agree. At 100 MHz with the default 16-bit counter each digit is lit for about 164 us per 655 us frame, a refresh rate of roughly 1.5 kHz per digit. The outputs are combinational in the counter and the live inputs, and all anodes stay off until the first clock edge after reset.

Top module: `status_scan`

## Requirements
- R1: While rst_ni is low, an_o is 4'b1111 and seg_o is 8'hFF; on the first rising clock edge after release the scan starts with AN0 (an_o = 4'b1110).
- R2: At most one bit of an_o is low at any time.
- R3: A CNT_W-bit counter, cleared by reset, increments on each rising edge; its top two bits n select digit n (an_o[n] low), so each digit stays lit for 2^(CNT_W-2) cycles, in the order AN0, AN1, AN2, AN3, then AN0 again.
- R4: seg_o bit 0 is segment a (top), bits 1 to 6 are b to g clockwise, bit 7 is the decimal point, all active low. While AN0 is lit, dir_left_i = 1 lights d, e, f ('L', active-high gfedcba 7'h38) and dir_left_i = 0 lights a, b, c, e, f, g ('A', 7'h77).
- R5: While AN1 or AN2 is lit, seg_o is 8'hFF.
- R6: While AN3 is lit and state_oh_i has exactly one bit set, at index i, the digit shows i in hex with active-high gfedcba patterns 0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F A:77 b:7C C:39 d:5E E:79 F:71 (idle is bit 0, L1 bit 1, L12 bit 2, L123 bit 3, R1 bit 4, R12 bit 5, R123 bit 6).
- R7: While AN3 is lit and state_oh_i is all zero or has two or more bits set, seg_o is 8'hFF.
- R8: The decimal point (seg_o[7]) is 1 on every digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| state_oh_i | input | STATE_W (16) | One-hot controller state |
| dir_left_i | input | 1 | 1 selects the left glyph, 0 the right glyph |
| an_o | output | 4 | Anode enables, active low, bit n for digit n |
| seg_o | output | 8 | Cathodes a to g and decimal point, active low |

## Verification
The anode pattern is due one register after each clock edge: the digit selected after the k-th edge since reset release is bits CNT_W-1:CNT_W-2 of k, and nothing is lit before the first edge. Cathode data has no register of its own, so a change of state_oh_i or dir_left_i is due in the same cycle, on whichever digit is lit. The bench counts edges since release, drives inputs on the falling edge and compares anodes and cathodes one nanosecond later against that count, every cycle, with a small counter width so that every digit appears under every input pattern.

// File: rtl/status_scan_pkg.sv
package status_scan_pkg;
  localparam int DIGITS = 4;
  localparam int SEG_W  = 8;
  localparam int HEX_W  = 4;

  typedef enum logic [1:0] {
    SLOT_DIR    = 2'd0,
    SLOT_BLANK1 = 2'd1,
    SLOT_BLANK2 = 2'd2,
    SLOT_STATE  = 2'd3
  } slot_e;

  // active-high, bit0 = a ... bit6 = g
  localparam logic [6:0] GLYPH_LEFT  = 7'h38;
  localparam logic [6:0] GLYPH_RIGHT = 7'h77;
  localparam logic [6:0] GLYPH_NONE  = 7'h00;
endpackage

// File: rtl/scan_counter.sv
module scan_counter #(
  parameter int CNT_W = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [1:0] sel_o,
  output logic       run_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      run_q <= 1'b1;
    end
  end

  assign sel_o = cnt_q[CNT_W-1 -: 2];
  assign run_o = run_q;
endmodule

// File: rtl/onehot_index.sv
module onehot_index #(
  parameter int STATE_W = 16,
  parameter int IDX_W   = $clog2(STATE_W)
) (
  input  logic [STATE_W-1:0] vec_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               valid_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < STATE_W; i++) begin
      if (vec_i[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

  // exactly one bit set
  assign valid_o = (vec_i != '0) && ((vec_i & (vec_i - 1'b1)) == '0);
endmodule

// File: rtl/hex_to_seg.sv
module hex_to_seg (
  input  logic [3:0] hex_i,
  output logic [6:0] lit_o
);
  always_comb begin
    unique case (hex_i)
      4'h0: lit_o = 7'h3F;
      4'h1: lit_o = 7'h06;
      4'h2: lit_o = 7'h5B;
      4'h3: lit_o = 7'h4F;
      4'h4: lit_o = 7'h66;
      4'h5: lit_o = 7'h6D;
      4'h6: lit_o = 7'h7D;
      4'h7: lit_o = 7'h07;
      4'h8: lit_o = 7'h7F;
      4'h9: lit_o = 7'h6F;
      4'hA: lit_o = 7'h77;
      4'hB: lit_o = 7'h7C;
      4'hC: lit_o = 7'h39;
      4'hD: lit_o = 7'h5E;
      4'hE: lit_o = 7'h79;
      default: lit_o = 7'h71;
    endcase
  end
endmodule

// File: rtl/status_scan.sv
module status_scan
  import status_scan_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int STATE_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STATE_W-1:0] state_oh_i,
  input  logic               dir_left_i,
  output logic [DIGITS-1:0]  an_o,
  output logic [SEG_W-1:0]   seg_o
);
  localparam int IDX_W = $clog2(STATE_W);

  logic [1:0]       sel;
  logic             run;
  logic [IDX_W-1:0] idx;
  logic             idx_ok;
  logic [6:0]       hex_lit;
  logic [6:0]       lit;

  scan_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_o (sel),
    .run_o (run)
  );

  onehot_index #(.STATE_W(STATE_W), .IDX_W(IDX_W)) i_idx (
    .vec_i  (state_oh_i),
    .idx_o  (idx),
    .valid_o(idx_ok)
  );

  hex_to_seg i_hex (
    .hex_i(HEX_W'(idx)),
    .lit_o(hex_lit)
  );

  for (genvar d = 0; d < DIGITS; d++) begin : g_an
    assign an_o[d] = !(run && (sel == 2'(d)));
  end

  always_comb begin
    unique case (slot_e'(sel))
      SLOT_DIR:   lit = dir_left_i ? GLYPH_LEFT : GLYPH_RIGHT;
      SLOT_STATE: lit = idx_ok ? hex_lit : GLYPH_NONE;
      default:    lit = GLYPH_NONE;
    endcase
  end

  // dp always dark; cathodes idle high while no anode is on
  assign seg_o = run ? {1'b1, ~lit} : {SEG_W{1'b1}};
endmodule

// File: rtl/status_scan_chk.sv
module status_scan_chk #(
  parameter int STATE_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [STATE_W-1:0] state_oh_i,
  input logic               dir_left_i,
  input logic [3:0]         an_o,
  input logic [7:0]         seg_o
);
  // R2
  one_anode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~an_o));

  // R3
  scan_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (an_o != 4'hF) |=> (an_o == $past(an_o)) || (an_o == {$past(an_o[2:0]), $past(an_o[3])}));

  // R5
  mid_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!an_o[1] || !an_o[2]) |-> (seg_o == 8'hFF));

  // R7
  bad_state_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!an_o[3] && ($countones(state_oh_i) != 1)) |-> (seg_o == 8'hFF));

  // R8
  dp_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_o[7]);
endmodule

bind status_scan status_scan_chk #(.STATE_W(STATE_W)) i_chk (.*);

// File: tb/test_status_scan.sv
`timescale 1ns/1ps
module test_status_scan;
  localparam int CNT_W = 4;
  localparam int SW    = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [SW-1:0] state_oh_i = '0;
  logic          dir_left_i = 1'b1;
  logic [3:0]    an_o;
  logic [7:0]    seg_o;

  int n_cmp = 0;
  int n_bad = 0;
  int k = 0;      // rising edges since reset release
  bit done = 0;

  status_scan #(.CNT_W(CNT_W), .STATE_W(SW)) i_status_scan (
    .clk_i(clk_i), .rst_ni(rst_ni), .state_oh_i(state_oh_i),
    .dir_left_i(dir_left_i), .an_o(an_o), .seg_o(seg_o)
  );

  always #2.5 clk_i = ~clk_i;

  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) k <= 0; else k <= k + 1;

  function automatic logic [6:0] hex_pat(int v);
    case (v)
      0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
      4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
      8: return 7'h7F;  9: return 7'h6F; 10: return 7'h77; 11: return 7'h7C;
     12: return 7'h39; 13: return 7'h5E; 14: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  task automatic compare();
    int digit, ones, pos;
    logic [3:0] exp_an;
    logic [7:0] exp_seg;
    string tag;
    if (!rst_ni || k == 0) begin
      digit = -1; exp_an = 4'hF; exp_seg = 8'hFF; tag = "R1";
    end else begin
      digit = (k % (1 << CNT_W)) >> (CNT_W - 2);
      exp_an = ~(4'b0001 << digit);
      ones = 0; pos = 0;
      for (int i = 0; i < SW; i++) if (state_oh_i[i]) begin ones++; pos = i; end
      case (digit)
        0: begin exp_seg = {1'b1, ~(dir_left_i ? 7'h38 : 7'h77)}; tag = "R4"; end
        3: if (ones == 1) begin exp_seg = {1'b1, ~hex_pat(pos)}; tag = "R6"; end
           else begin exp_seg = 8'hFF; tag = "R7"; end
        default: begin exp_seg = 8'hFF; tag = "R5"; end
      endcase
    end
    n_cmp++;
    if (an_o !== exp_an) begin
      n_bad++;
      $display("FAIL %s an_o got %b expected %b (k=%0d)",
               ($countones(~an_o) > 1) ? "R2" : (rst_ni && k > 0 ? "R3" : "R1"), an_o, exp_an, k);
    end
    n_cmp++;
    if (seg_o !== exp_seg) begin
      n_bad++;
      $display("FAIL %s seg_o got %h expected %h (k=%0d)",
               (seg_o[7] !== 1'b1) ? "R8" : tag, seg_o, exp_seg, k);
    end
  endtask

  task automatic run(logic [SW-1:0] vec, logic left, int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk_i);
      state_oh_i = vec;
      dir_left_i = left;
      #1 compare();
    end
  endtask

  initial begin
    // R1: held in reset, nothing lit
    run(16'h0001, 1'b1, 3);
    @(negedge clk_i); rst_ni = 1'b1; #1 compare();
    // R3: full rotation checks AN0..AN3 order; R6 each index, R4 both glyphs
    for (int i = 0; i < SW; i++) begin
      run(16'h0001 << i, 1'b1, 1 << CNT_W);
      run(16'h0001 << i, 1'b0, 1 << CNT_W);
    end
    // R7: zero and multi-bit vectors
    run(16'h0000, 1'b1, 1 << CNT_W);
    run(16'h0003, 1'b0, 1 << CNT_W);
    run(16'h8001, 1'b1, 1 << CNT_W);
    run(16'hFFFF, 1'b0, 1 << CNT_W);
    // same-cycle input changes while the state digit is lit
    for (int i = 0; i < 48; i++) run(16'h0001 << (i % 7), i[0], 1);
    // R1: reset mid-scan clears anodes at once and restarts at AN0
    @(negedge clk_i); rst_ni = 1'b0; #1 compare();
    run(16'h0004, 1'b1, 2);
    @(negedge clk_i); rst_ni = 1'b1; #1 compare();
    run(16'h0040, 1'b0, 2 << CNT_W);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired (k=%0d)", k);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule